// File: doc/BRIEF.md
# Programmable-Density Pseudorandom Bit Source

This block emits a stream of pseudorandom bits whose fraction of ones is chosen while it runs, down to very low values. It is meant for stimulus generators, dithering and traffic shapers that need a rare-event stream rather than the usual half-ones output of a shift register. Each produced bit comes with a one-cycle valid strobe.

There are two ways to make a bit. In the threshold mode a bank of independently seeded 32-bit shift registers contributes one fresh bit each per clock. The bits form a uniform word that is compared against a programmable threshold, which gives a density of threshold/2^LANES at one bit per clock. In the gated mode a single shift register is advanced one step per clock. A group of consecutive output bits is collected, and a one is emitted only when the whole group is zero, which gives a density of 1/8 for the default group of three at one bit per three clocks. Bits are never taken from several positions of one register state in the same clock, because those positions are only delayed copies of one sequence.

Top module: `density_bitgen`

## Requirements
- R1: While reset is asserted (active low, asynchronous), bit_o and valid_o are 0. Reset loads every shift register with its seed.
- R2: Every shift register is 32 bits wide and shifts toward the MSB. The new bit 0 is the XOR of state bits 31, 21, 1 and 0, and the bit a register emits on a step is bit 31 before the step. No register state is ever all-zero.
- R3: Bank lane k (k = 0..LANES-1) is seeded with (32'h9E3779B9 * (k+1)) mod 2^32 OR 1. The gated-mode register uses the same formula with k = LANES.
- R4: In threshold mode (mode_i = 0), an enabled clock that is not inside a gated sample steps all lanes once. Lane k's emitted bit becomes bit k of a word W, and on the next cycle valid_o = 1 and bit_o = (W < thr_i) as unsigned values.
- R5: A threshold of 0 makes every threshold-mode bit 0.
- R6: In gated mode (mode_i = 1), each enabled clock steps only the gated register. After COARSE_BITS enabled steps valid_o pulses with bit_o = 1 exactly when all of those emitted bits were 0, so one bit is produced per three enabled clocks by default.
- R7: The mode is sampled only when a sample starts. A change of mode_i while a gated sample is in progress has no effect until that sample completes.
- R8: With en_i = 0 no register steps, valid_o is 0 on the next cycle and bit_o keeps its value. A paused gated sample resumes where it stopped.
- R9: bit_o changes only in a cycle where valid_o is 1.
- R10: Over many samples the measured density is close to thr_i/65536 in threshold mode and close to 1/8 in gated mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the generator this clock |
| mode_i | input | 1 | 0 = threshold mode, 1 = gated mode |
| thr_i | input | LANES (16) | Threshold for threshold mode |
| bit_o | output | 1 | Generated bit, held between strobes |
| valid_o | output | 1 | One-cycle strobe marking a new bit |

## Verification
The assertions assume that en_i, mode_i and thr_i are synchronous to clk_i and stable around its rising edge. They also assume that reset is only released while the block is idle. The stimulus changes every input on the falling edge and releases reset with enable low. Mode switches are deliberately placed in the middle of gated samples, and enable is dropped both between samples and inside them, so that the properties on sample completion and pausing are exercised within those assumptions.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

   localparam int unsigned LFSR_W = 32;

   typedef enum logic {
      MODE_FINE   = 1'b0,
      MODE_COARSE = 1'b1
   } dbg_mode_e;

   // Seed for lane idx; low bit forced so the state is never all-zero.
   function automatic logic [LFSR_W-1:0] seed_for(input int unsigned idx);
      logic [LFSR_W-1:0] prod;
      prod = 32'h9E3779B9 * LFSR_W'(idx + 1);
      return prod | 32'h1;
   endfunction

   // One Fibonacci step, taps 32,22,2,1 (one-based).
   function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

endpackage

// File: rtl/dbg_lfsr.sv
module dbg_lfsr #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] SEED = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   if (W != dbg_pkg::LFSR_W) begin : g_bad_width
      $error("dbg_lfsr: W must equal the package register width");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("dbg_lfsr: an all-zero seed locks the register");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     state_o <= SEED;
      else if (step_i) state_o <= dbg_pkg::lfsr_next(state_o);
   end
endmodule

// File: rtl/dbg_lane_bank.sv
module dbg_lane_bank #(
   parameter int unsigned LANES = 16,
   parameter int unsigned W     = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   output logic [LANES-1:0] word_o,
   output logic             live_o
);
   logic [LANES-1:0] lane_live;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [W-1:0] st;
      dbg_lfsr #(
         .W   (W),
         .SEED(dbg_pkg::seed_for(k))
      ) u_lfsr (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .step_i (step_i),
         .state_o(st)
      );
      assign word_o[k]    = st[W-1];
      assign lane_live[k] = |st;
   end

   assign live_o = &lane_live;
endmodule

// File: rtl/dbg_coarse_gate.sv
module dbg_coarse_gate #(
   parameter int unsigned GROUP    = 3,
   parameter int unsigned SEED_IDX = 16,
   parameter int unsigned W        = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   output logic         busy_o,
   output logic         done_o,
   output logic         zero_o,
   output logic [W-1:0] state_o
);
   localparam int unsigned CNT_W = (GROUP > 1) ? $clog2(GROUP) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);

   if (GROUP < 1) begin : g_bad_group
      $error("dbg_coarse_gate: GROUP must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             acc;
   logic             tap;

   dbg_lfsr #(
      .W   (W),
      .SEED(dbg_pkg::seed_for(SEED_IDX))
   ) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step_i),
      .state_o(state_o)
   );

   assign tap = state_o[W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt <= '0;
         acc <= 1'b1;
      end else if (step_i) begin
         if (cnt == LAST) begin
            cnt <= '0;
            acc <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
            acc <= acc & ~tap;
         end
      end
   end

   assign busy_o = (cnt != '0);
   assign done_o = step_i && (cnt == LAST);
   assign zero_o = acc & ~tap;
endmodule

// File: rtl/density_bitgen.sv
module density_bitgen #(
   parameter int unsigned LANES       = 16,
   parameter int unsigned COARSE_BITS = 3,
   parameter int unsigned W           = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             mode_i,
   input  logic [LANES-1:0] thr_i,
   output logic             bit_o,
   output logic             valid_o
);
   import dbg_pkg::*;

   if (LANES < 1 || LANES > 32) begin : g_bad_lanes
      $error("density_bitgen: LANES must lie in 1..32");
   end
   if (W != LFSR_W) begin : g_bad_w
      $error("density_bitgen: W must match the register width");
   end

   dbg_mode_e        mode_sel;
   logic             crs_busy, crs_done, crs_zero, lanes_live;
   logic [W-1:0]     crs_state;
   logic [LANES-1:0] lane_word;
   logic             fine_go, crs_go;

   assign mode_sel = dbg_mode_e'(mode_i);
   // a gated sample in flight keeps ownership until it completes
   assign fine_go  = en_i && !crs_busy && (mode_sel == MODE_FINE);
   assign crs_go   = en_i && (crs_busy || (mode_sel == MODE_COARSE));

   dbg_lane_bank #(
      .LANES(LANES),
      .W    (W)
   ) u_bank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(fine_go),
      .word_o(lane_word),
      .live_o(lanes_live)
   );

   dbg_coarse_gate #(
      .GROUP   (COARSE_BITS),
      .SEED_IDX(LANES),
      .W       (W)
   ) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (crs_go),
      .busy_o (crs_busy),
      .done_o (crs_done),
      .zero_o (crs_zero),
      .state_o(crs_state)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_o   <= 1'b0;
         valid_o <= 1'b0;
      end else if (fine_go) begin
         bit_o   <= (lane_word < thr_i);
         valid_o <= 1'b1;
      end else if (crs_done) begin
         bit_o   <= crs_zero;
         valid_o <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/density_bitgen_chk.sv
module density_bitgen_chk #(
   parameter int unsigned LANES = 16,
   parameter int unsigned W     = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             mode_i,
   input logic [LANES-1:0] thr_i,
   input logic             bit_o,
   input logic             valid_o,
   input logic             busy_i,
   input logic             live_i,
   input logic [W-1:0]     crs_state_i
);
   a_r2_no_dead_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_i && (crs_state_i != '0));

   a_r4_fine_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !busy_i && !mode_i) |=> valid_o);

   a_r5_zero_thr_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !busy_i && !mode_i && thr_i == '0) |=> !bit_o);

   a_r7_sample_runs_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && busy_i) |=> (busy_i || valid_o));

   a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!valid_o && $stable(bit_o)));

   a_r9_bit_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(bit_o) |-> valid_o);
endmodule

bind density_bitgen density_bitgen_chk #(
   .LANES(LANES),
   .W    (W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .en_i       (en_i),
   .mode_i     (mode_i),
   .thr_i      (thr_i),
   .bit_o      (bit_o),
   .valid_o    (valid_o),
   .busy_i     (crs_busy),
   .live_i     (lanes_live),
   .crs_state_i(crs_state)
);

// File: tb/density_bitgen_test.sv
module density_bitgen_test;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          en_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [NL-1:0] thr_i = '0;
   logic          bit_o, valid_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   density_bitgen uut (
      .clk_i  (clk),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .mode_i (mode_i),
      .thr_i  (thr_i),
      .bit_o  (bit_o),
      .valid_o(valid_o)
   );

   typedef struct {
      logic v;
      logic b;
      int   req;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] m_lane[NL];
   logic [31:0] m_crs;
   int          m_cnt = 0;
   logic        m_acc = 1'b1;
   logic        m_bit = 1'b0;
   bit          dens_on = 0;
   int          dens_n = 0;
   int          dens_ones = 0;
   bit          done = 0;

   // R2 step rule, written from the requirement
   function automatic logic [31:0] adv(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // R3 seed rule
   function automatic logic [31:0] seed(input int k);
      return (32'h9E3779B9 * 32'(k + 1)) | 32'h1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic drive(input logic en, input logic md, input logic [NL-1:0] thr, input int req);
      exp_t          e;
      logic [NL-1:0] w;
      logic          tb;
      @(negedge clk);
      en_i = en; mode_i = md; thr_i = thr;
      e.v = 1'b0;
      if (en && m_cnt == 0 && md == 1'b0) begin
         for (int k = 0; k < NL; k++) w[k] = m_lane[k][31];
         m_bit = (w < thr);
         e.v = 1'b1;
         for (int k = 0; k < NL; k++) m_lane[k] = adv(m_lane[k]);
      end else if (en) begin
         tb = m_crs[31];
         m_crs = adv(m_crs);
         if (m_cnt == 2) begin
            m_bit = m_acc & ~tb;
            m_cnt = 0;
            m_acc = 1'b1;
            e.v = 1'b1;
         end else begin
            m_acc = m_acc & ~tb;
            m_cnt++;
         end
      end
      e.b = m_bit;
      e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compares one queued item per clock, after the outputs settle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(valid_o == e.v, $sformatf("R%0d valid", e.req), int'(valid_o), int'(e.v));
            check(bit_o == e.b, $sformatf("R%0d bit", e.req), int'(bit_o), int'(e.b));
            if (dens_on && valid_o) begin
               dens_n++;
               dens_ones += int'(bit_o);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int k = 0; k < NL; k++) m_lane[k] = seed(k);
      m_crs = seed(NL);
      repeat (3) @(negedge clk);
      // R1: outputs held low during reset
      check(bit_o == 1'b0, "R1 bit in reset", int'(bit_o), 0);
      check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
      @(negedge clk);
      rst_ni = 1'b1;

      // R4 / R3: threshold mode from the seeded lanes, mid threshold
      for (int i = 0; i < 200; i++) drive(1'b1, 1'b0, 16'h8000, 4);
      // R5: zero threshold never yields a one
      dens_on = 1; dens_n = 0; dens_ones = 0;
      for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, 16'h0000, 5);
      drive(1'b0, 1'b0, 16'h0000, 8);
      dens_on = 0;
      check(dens_ones == 0, "R5 ones at zero threshold", dens_ones, 0);
      // R4: full-scale threshold
      for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, 16'hFFFF, 4);
      // R6: gated mode, one bit per three clocks
      for (int i = 0; i < 300; i++) drive(1'b1, 1'b1, 16'h1234, 6);
      // R7: mode flips to threshold inside a gated sample
      for (int i = 0; i < 20; i++) begin
         drive(1'b1, 1'b1, 16'h4000, 7);
         drive(1'b1, 1'b0, 16'h4000, 7);
         drive(1'b1, 1'b0, 16'h4000, 7);
         drive(1'b1, 1'b0, 16'h4000, 7);
      end
      // R8: enable dropped between and inside samples
      for (int i = 0; i < 20; i++) begin
         drive(1'b1, 1'b1, 16'h2000, 8);
         drive(1'b0, 1'b0, 16'h2000, 8);
         drive(1'b0, 1'b1, 16'h2000, 8);
         drive(1'b1, 1'b0, 16'h2000, 8);
         drive(1'b1, 1'b1, 16'h2000, 8);
         drive(1'b0, 1'b0, 16'hFFFF, 8);
         drive(1'b1, 1'b0, 16'h2000, 8);
      end
      // R10: density in threshold mode, 2^16 samples at thr = 8192
      dens_on = 1; dens_n = 0; dens_ones = 0;
      for (int i = 0; i < 65536; i++) drive(1'b1, 1'b0, 16'd8192, 10);
      drive(1'b0, 1'b0, 16'd0, 8);
      dens_on = 0;
      check(dens_ones > 8192 - 512 && dens_ones < 8192 + 512,
            "R10 threshold density", dens_ones, 8192);
      // R10: density in gated mode, 2^14 samples, expect 1/8
      dens_on = 1; dens_n = 0; dens_ones = 0;
      for (int i = 0; i < 3 * 16384; i++) drive(1'b1, 1'b1, 16'd0, 10);
      drive(1'b0, 1'b0, 16'd0, 8);
      dens_on = 0;
      check(dens_n == 16384, "R6 gated sample count", dens_n, 16384);
      check(dens_ones > 2048 - 256 && dens_ones < 2048 + 256,
            "R10 gated density", dens_ones, 2048);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule